// File: doc/BRIEF.md
# Fiducial-Started Event Code Sequencer

This block sits on the transmit side of a timing distribution link. It produces one 16-bit link word in every reference clock cycle. The low byte of each word is an event code and the high byte is a distributed data byte. The data byte is taken from an input port and sent unchanged, one cycle late. The event codes come from a two-bank sequence store. Each entry in the store pairs a cycle offset with an 8-bit code. A fiducial pulse starts playback of the active bank. Playback walks the entries in address order and places each entry's code on the link in the cycle its offset names. In every other cycle the code field carries the null code 0x00.

Host logic fills the bank that is not playing, through a simple write port. It then asks for a bank swap. The swap waits for the next fiducial, so the sequence being played never changes while it runs. The sequence ends at an entry holding the terminator code 0x7F, or after the last address has been emitted. If a fiducial arrives while playback is still running, playback restarts and a sticky overrun flag is set.

Top module: `fidseq_top`

## Requirements
- R1: Whenever reset was low at the previous rising edge, `link_valid` is 1. `link_word[15:8]` then equals the `data_byte` value that was present at that edge.
- R2: While `rst` is high, `link_word`, `link_valid` and `overrun` are 0. Bank 0 becomes the active bank and no swap is pending. Stored entries are kept.
- R3: Call E0 the rising edge at which `fiducial` is high. An active-bank entry with offset k (offsets strictly increasing from address 0) puts its code in `link_word[7:0]` after edge E(k+1). Entries are emitted in address order.
- R4: `link_word[7:0]` is 0x00 after every edge at which no entry is emitted. This includes the fiducial edge itself and all idle cycles.
- R5: An entry whose code is 0x7F ends playback and is never transmitted. No further code is sent until the next fiducial.
- R6: When no terminator is present, playback ends after the entry at the last address (DEPTH-1) has been emitted.
- R7: A fiducial that arrives before playback has ended restarts playback at entry 0 and sets `overrun`. The edge at which the terminator is detected still counts as playback. `overrun` stays 1 until reset.
- R8: A host write (`wr_en`, `wr_addr`, `wr_offset`, `wr_code`) stores into the inactive bank only. It has no effect on the words produced from the active bank.
- R9: A `swap_req` pulse makes the inactive bank active at the next fiducial edge, or at the same edge if both are high together. Without a swap request, a fiducial replays the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one link word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fiducial | input | 1 | One-cycle pulse that starts playback |
| swap_req | input | 1 | One-cycle request to swap banks at the next fiducial |
| wr_en | input | 1 | Host write strobe into the inactive bank |
| wr_addr | input | $clog2(DEPTH) | Entry address for the host write |
| wr_offset | input | 24 | Cycle offset from the fiducial for the entry |
| wr_code | input | 8 | Event code for the entry |
| data_byte | input | 8 | Distributed data byte for the high half of the word |
| link_word | output | 16 | Link word: {data byte, event code} |
| link_valid | output | 1 | Word strobe, high every cycle out of reset |
| overrun | output | 1 | Sticky flag: a fiducial arrived during playback |

## Verification
Every result comes from a single output register. The data byte and the `link_valid` strobe therefore follow their inputs by exactly one edge. An entry with offset k appears after the (k+1)-th edge counted from the fiducial edge. The overrun flag rises at the fiducial edge that interrupts playback. The bench drives each input on a falling edge, lets one rising edge pass, and compares the word and the flag on the next falling edge. Its expectations come from an edge count kept since the last fiducial and from a shadow copy of the two banks. This timing also puts the terminator-edge overrun boundary, and the edge just after it, at known cycles.

// File: rtl/fidseq_pkg.sv
package fidseq_pkg;

    localparam int CODE_W = 8;
    localparam int OFS_W  = 24;

    localparam logic [CODE_W-1:0] CODE_NULL = 8'h00;
    localparam logic [CODE_W-1:0] CODE_TERM = 8'h7F;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [CODE_W-1:0] code;
    } seq_entry_t;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_RUN  = 1'b1
    } play_state_e;

    function automatic logic is_term(input logic [CODE_W-1:0] c);
        return c == CODE_TERM;
    endfunction

endpackage

// File: rtl/fidseq_bank_ctl.sv
module fidseq_bank_ctl (
    input  logic clk,
    input  logic rst,
    input  logic fiducial,
    input  logic swap_req,
    output logic active_bank
);

    logic swap_pend_q;
    logic swap_due;

    assign swap_due = swap_pend_q | swap_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_bank <= 1'b0;
            swap_pend_q <= 1'b0;
        end else if (fiducial) begin
            if (swap_due) begin
                active_bank <= ~active_bank;
            end
            swap_pend_q <= 1'b0;
        end else if (swap_req) begin
            swap_pend_q <= 1'b1;
        end
    end

    // The active bank may only change at a fiducial edge.
    assert_bank_only_at_fid_R9: assert property (@(posedge clk) disable iff (rst)
        !fiducial |=> $stable(active_bank));

    // A fiducial with nothing pending leaves the bank unchanged.
    assert_no_swap_no_flip_R9: assert property (@(posedge clk) disable iff (rst)
        (fiducial && !swap_pend_q && !swap_req) |=> $stable(active_bank));

endmodule

// File: rtl/fidseq_ram.sv
module fidseq_ram
    import fidseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             active_bank,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  seq_entry_t       wr_entry,
    input  logic [AW-1:0]    rd_addr,
    output seq_entry_t       rd_entry
);

    localparam int NBANK = 2;

    seq_entry_t bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        seq_entry_t store_q [DEPTH];
        logic       sel_wr;

        assign sel_wr = wr_en && (active_bank != 1'(b));

        always_ff @(posedge clk) begin
            if (sel_wr) begin
                store_q[wr_addr] <= wr_entry;
            end
        end

        assign bank_rd[b] = store_q[rd_addr];
    end

    assign rd_entry = bank_rd[active_bank];

endmodule

// File: rtl/fidseq_player.sv
module fidseq_player
    import fidseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fiducial,
    input  seq_entry_t        entry,
    output logic [AW-1:0]     rd_addr,
    output logic [CODE_W-1:0] emit_code,
    output logic              overrun
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    play_state_e       st_q;
    logic [OFS_W-1:0]  cnt_q;
    logic [AW-1:0]     idx_q;
    logic              ovr_q;
    logic              due;

    assign due = (st_q == PL_RUN) && !is_term(entry.code) && (entry.ofs == cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PL_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            ovr_q <= 1'b0;
        end else if (fiducial) begin
            if (st_q == PL_RUN) begin
                ovr_q <= 1'b1;
            end
            st_q  <= PL_RUN;
            cnt_q <= '0;
            idx_q <= '0;
        end else if (st_q == PL_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            if (is_term(entry.code)) begin
                st_q <= PL_IDLE;
            end else if (due) begin
                if (idx_q == LAST_IDX) begin
                    st_q <= PL_IDLE;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        emit_code = CODE_NULL;
        if (due && !fiducial) begin
            emit_code = entry.code;
        end
    end

    assign rd_addr = idx_q;
    assign overrun = ovr_q;

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);

    assert_fid_restart_R7: assert property (@(posedge clk) disable iff (rst)
        fiducial |=> (st_q == PL_RUN && idx_q == '0 && cnt_q == '0));

    assert_idx_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == PL_RUN && !fiducial) |=>
            (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == PL_IDLE && !fiducial) |=> st_q == PL_IDLE);

endmodule

// File: rtl/fidseq_top.sv
module fidseq_top
    import fidseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fiducial,
    input  logic              swap_req,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [OFS_W-1:0]  wr_offset,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [CODE_W-1:0] data_byte,
    output logic [2*CODE_W-1:0] link_word,
    output logic              link_valid,
    output logic              overrun
);

    logic              active_bank;
    logic [AW-1:0]     rd_addr;
    seq_entry_t        rd_entry;
    seq_entry_t        wr_entry;
    logic [CODE_W-1:0] emit_code;

    assign wr_entry = '{ofs: wr_offset, code: wr_code};

    fidseq_bank_ctl u_bank (
        .clk         (clk),
        .rst         (rst),
        .fiducial    (fiducial),
        .swap_req    (swap_req),
        .active_bank (active_bank)
    );

    fidseq_ram #(.DEPTH(DEPTH)) u_ram (
        .clk         (clk),
        .active_bank (active_bank),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_entry    (wr_entry),
        .rd_addr     (rd_addr),
        .rd_entry    (rd_entry)
    );

    fidseq_player #(.DEPTH(DEPTH)) u_play (
        .clk       (clk),
        .rst       (rst),
        .fiducial  (fiducial),
        .entry     (rd_entry),
        .rd_addr   (rd_addr),
        .emit_code (emit_code),
        .overrun   (overrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            link_word  <= '0;
            link_valid <= 1'b0;
        end else begin
            link_word  <= {data_byte, emit_code};
            link_valid <= 1'b1;
        end
    end

    assert_valid_each_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> link_valid);

    assert_data_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> link_word[2*CODE_W-1:CODE_W] == $past(data_byte));

    assert_fid_word_null_R4: assert property (@(posedge clk) disable iff (rst)
        fiducial |=> link_word[CODE_W-1:0] == CODE_NULL);

    assert_term_never_sent_R5: assert property (@(posedge clk) disable iff (rst)
        link_word[CODE_W-1:0] != CODE_TERM);

endmodule

// File: tb/fidseq_top_tb_top.sv
module fidseq_top_tb_top;
    import fidseq_pkg::*;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst;
    logic              fiducial;
    logic              swap_req;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [OFS_W-1:0]  wr_offset;
    logic [CODE_W-1:0] wr_code;
    logic [CODE_W-1:0] data_byte;
    logic [15:0]       link_word;
    logic              link_valid;
    logic              overrun;

    always #10 clk = ~clk;

    fidseq_top #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .fiducial(fiducial), .swap_req(swap_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_offset(wr_offset),
        .wr_code(wr_code), .data_byte(data_byte),
        .link_word(link_word), .link_valid(link_valid), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    // Bench-side picture of the two banks and of the playback timeline.
    logic [OFS_W-1:0]  sh_ofs  [2][DEPTH];
    logic [CODE_W-1:0] sh_code [2][DEPTH];
    int act_m, pend_m, sess_m, k_m, end_edge_m, len_m, ovr_m;
    logic [7:0] dseed = 8'h5A;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Length up to the terminator, and the edge at which playback ends.
    task automatic snap_session();
        len_m = DEPTH;
        for (int i = 0; i < DEPTH; i++) begin
            if (sh_code[act_m][i] == CODE_TERM) begin
                len_m = i;
                break;
            end
        end
        if (len_m == 0)          end_edge_m = 1;
        else if (len_m == DEPTH) end_edge_m = int'(sh_ofs[act_m][DEPTH-1]) + 1;
        else                     end_edge_m = int'(sh_ofs[act_m][len_m-1]) + 2;
    endtask

    task automatic step(input bit fid, input bit swp, input bit we,
                        input int wa, input int wo, input logic [7:0] wc);
        logic [7:0] dv;
        logic [7:0] ecode;
        dv    = dseed;
        dseed = dseed * 8'd5 + 8'd3;
        fiducial  = fid;
        swap_req  = swp;
        wr_en     = we;
        wr_addr   = AW'(wa);
        wr_offset = OFS_W'(wo);
        wr_code   = wc;
        data_byte = dv;
        ecode = 8'h00;
        if (we) begin
            sh_ofs[1-act_m][wa]  = OFS_W'(wo);
            sh_code[1-act_m][wa] = wc;
        end
        if (swp) pend_m = 1;
        if (fid) begin
            if (sess_m != 0 && (k_m + 1) <= end_edge_m) ovr_m = 1;
            if (pend_m != 0) begin
                act_m  = 1 - act_m;
                pend_m = 0;
            end
            snap_session();
            sess_m = 1;
            k_m    = 0;
        end else if (sess_m != 0) begin
            k_m++;
            for (int i = 0; i < len_m; i++) begin
                if (int'(sh_ofs[act_m][i]) == k_m - 1) ecode = sh_code[act_m][i];
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (ecode != 8'h00) chk("R3 code", 32'(link_word[7:0]), 32'(ecode));
        else                chk("R4 null", 32'(link_word[7:0]), 32'h0);
        chk("R1 data+valid", {23'd0, link_valid, link_word[15:8]}, {23'd0, 1'b1, dv});
        chk("R7 overrun", 32'(overrun), 32'(ovr_m));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic wr(input int a, input int o, input logic [7:0] c);
        step(0, 0, 1, a, o, c);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fiducial = 0; swap_req = 0; wr_en = 0; wr_addr = '0;
        wr_offset = '0; wr_code = '0; data_byte = 8'hFF;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2 word", 32'(link_word), 32'h0);
            chk("R2 valid", 32'(link_valid), 32'h0);
            chk("R2 overrun", 32'(overrun), 32'h0);
        end
        rst = 1'b0;
        act_m = 0; pend_m = 0; sess_m = 0; k_m = 0; ovr_m = 0;
        end_edge_m = 0; len_m = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog got hang exp finish");
            report();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        idle(4);                                  // R1, R4 idle words

        // Sequence A into bank 1, terminated (R3, R5).
        wr(0, 0, 8'h11); wr(1, 3, 8'h22); wr(2, 4, 8'h33);
        wr(3, 10, 8'h44); wr(4, 0, CODE_TERM);
        step(0, 1, 0, 0, 0, 8'h00);               // R9 swap request
        idle(3);                                  // no fiducial: nothing yet
        step(1, 0, 0, 0, 0, 8'h00);
        idle(14);

        // Replay A without a swap (R9) while loading bank 0 (R8).
        step(1, 0, 0, 0, 0, 8'h00);
        for (int i = 0; i < DEPTH; i++) wr(i, 2*i + 1, 8'(8'h80 + i));
        idle(2);

        // Swap with fiducial on the same edge: sequence B, no terminator (R6).
        step(1, 1, 0, 0, 0, 8'h00);
        idle(10);
        step(1, 0, 0, 0, 0, 8'h00);               // R7 overrun, restart
        idle(40);                                 // B runs to address DEPTH-1

        // Sweep of a single entry over small offsets.
        for (int g = 0; g < 6; g++) begin
            wr(0, g, 8'(8'h50 + g));
            wr(1, 0, CODE_TERM);
            step(0, 1, 0, 0, 0, 8'h00);
            step(1, 0, 0, 0, 0, 8'h00);
            idle(g + 4);
        end

        // Terminator at entry 0 and edge-exact overrun boundaries (R5, R7).
        do_reset();
        wr(0, 0, CODE_TERM);
        step(1, 1, 0, 0, 0, 8'h00);
        idle(1);
        step(1, 0, 0, 0, 0, 8'h00);               // edge after end: no overrun
        idle(3);

        do_reset();
        wr(0, 2, 8'h66); wr(1, 0, CODE_TERM);
        step(1, 1, 0, 0, 0, 8'h00);
        idle(4);
        step(1, 0, 0, 0, 0, 8'h00);               // E5: after end, R7 stays 0
        idle(3);
        step(1, 0, 0, 0, 0, 8'h00);               // E4: terminator edge, R7 sets
        idle(6);

        done = 1;
        report();
    end

endmodule